// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block loads a configuration bitstream into an SRAM-based programmable target over a passive serial link. On a start pulse it holds the target's configuration-reset line low for a programmed number of system cycles and then releases it. It waits until the target lets its open-drain status line go high. It then shifts bytes from an upstream byte stream onto a single data line, with a configuration clock made by dividing the system clock. Once the last byte is out, it keeps clocking until the target raises configuration-done. It gives a programmed number of extra clocks, and it can then wait for the target's initialization-done line. The result is reported as done or error.

The byte stream uses valid/ready. A byte moves when `s_valid` and `s_ready` are both high at a rising system clock edge. While `s_valid` is high and `s_ready` is low, the source must hold `s_data` and `s_last` unchanged. The host raises `s_ready` only when it has finished the previous byte and the configuration clock is low. If no byte is offered, the configuration clock waits low, so a slow source only stretches the load. The three target inputs pass through a synchronizer before the sequencer uses them. Setting `WAIT_INIT` to 0 drops the wait for initialization-done.

Top module: `ps_cfg_host`

## Requirements
- R1: After system reset, `tgt_rst_n`, `cfg_clk`, `cfg_data`, `busy`, `done`, `error` and `s_ready` are all low.
- R2: A `start` pulse taken while idle makes `busy` high from the next cycle and holds `tgt_rst_n` low for exactly max(`hold_cycles`,1) system cycles before driving it high.
- R3: After the reset is released, no rising `cfg_clk` edge occurs and no byte is accepted until the synchronized status input has been seen low and then high.
- R4: Each byte is sent least-significant bit (bit 0) first, one bit per rising `cfg_clk` edge. `cfg_data` changes only on system edges where `cfg_clk` is low before and after the edge, so it is stable at least one system cycle before each rising edge.
- R5: Every high phase of `cfg_clk` lasts exactly max(`clk_div`,1) system cycles, and every low phase lasts at least that long.
- R6: `s_ready` is high only while loading, with no bits of the current byte left and `cfg_clk` low. A byte is taken only when `tgt_rst_n` is high.
- R7: After the byte marked by `s_last` has been shifted, `cfg_clk` keeps toggling until configuration-done is seen. Exactly `extra_clks` further rising edges then follow. With `WAIT_INIT` set, the host waits for initialization-done with the clock parked. It then raises `done` and drops `busy`.
- R8: If the status input reads low while bytes are being shifted, the host raises `error`, drops `busy` and drives `tgt_rst_n` low.
- R9: If the status input (after release), configuration-done or initialization-done is not high within `timeout` system cycles of the wait starting, the host raises `error`, drops `busy` and drives `tgt_rst_n` low.
- R10: Once a load ends, `cfg_clk` and `cfg_data` settle low and stay low. After a successful load, `tgt_rst_n` stays high.
- R11: `done` and `error` are never high together. They hold until the next `start` taken while idle. A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken only while idle) |
| clk_div | input | DIV_W | Half period of the configuration clock in system cycles (0 acts as 1) |
| hold_cycles | input | HOLD_W | Minimum low time of the target reset (0 acts as 1) |
| timeout | input | TO_W | Limit in system cycles for each wait on a target input |
| extra_clks | input | EXT_W | Clock edges given after configuration-done |
| s_data | input | BYTE_W | Bitstream byte |
| s_valid | input | 1 | Byte offered |
| s_last | input | 1 | Offered byte is the final one |
| s_ready | output | 1 | Host takes the byte at this edge |
| tgt_rst_n | output | 1 | Configuration reset to the target, active low |
| tgt_status | input | 1 | Open-drain status from the target |
| tgt_done | input | 1 | Configuration-done from the target |
| tgt_init | input | 1 | Initialization-done from the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_data | output | 1 | Serial data to the target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed |
| error | output | 1 | Last load failed |

## Verification
A wrong sequencer state shows up first on `tgt_rst_n` and `cfg_clk`. A wrong reset length, or a clock edge before the status release, appears within one configuration-clock period. A slip in the bit counter or shift register shows as a wrong byte at the target model on the next byte boundary. An off-by-one in the trailing-clock counter shows as a wrong count of edges after configuration-done, before `done` rises. Abort paths show within the timeout window as `error` without `done` and with the target reset pulled low again.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAITST,
    ST_SHIFT,
    ST_WAITDN,
    ST_FLUSH,
    ST_WAITIN
  } cfg_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/cfg_divider.sv
module cfg_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_last;

  assign half_last = (half == '0) ? '0 : half - 1'b1;
  assign tick      = run && (cnt == half_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(tick) && $stable(half)) |-> (cnt != '0));

endmodule

// File: rtl/cfg_serializer.sv
module cfg_serializer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              shift_en,
  input  logic              toggle_en,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  output logic              s_ready,
  output logic              dclk,
  output logic              dout,
  output logic              rise,
  output logic              byte_done
);

  localparam int LW = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sh;
  logic [LW-1:0]     left;
  logic              adv;
  logic              have;
  logic              take;
  logic              fall;
  logic              step;

  assign have      = (left != '0);
  assign s_ready   = shift_en && !have && !dclk;
  assign take      = s_valid && s_ready;
  assign rise      = tick && !dclk && ((shift_en && have && !adv) || toggle_en);
  assign fall      = tick && dclk;
  assign step      = shift_en && !dclk && adv;
  assign byte_done = step && (left == LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk <= 1'b0;
      dout <= 1'b0;
      sh   <= '0;
      left <= '0;
      adv  <= 1'b0;
    end else begin
      if (rise)      dclk <= 1'b1;
      else if (fall) dclk <= 1'b0;

      if (!shift_en) begin
        left <= '0;
        adv  <= 1'b0;
        if (!toggle_en && !dclk) dout <= 1'b0;
      end else if (take) begin
        sh   <= s_data;
        dout <= s_data[0];
        left <= LW'(BYTE_W);
        adv  <= 1'b0;
      end else if (step) begin
        sh   <= {1'b0, sh[BYTE_W-1:1]};
        dout <= sh[1];
        left <= left - 1'b1;
        adv  <= 1'b0;
      end else if (rise && have) begin
        adv  <= 1'b1;
      end
    end
  end

  a_r4_data_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> (!$past(dclk) && !dclk));

  a_r10_clock_stays_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !toggle_en && !dclk) |=> !dclk);

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_host_pkg::*;
#(
  parameter int HOLD_W    = 8,
  parameter int TO_W      = 16,
  parameter int EXT_W     = 4,
  parameter bit WAIT_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic [TO_W-1:0]   timeout,
  input  logic [EXT_W-1:0]  extra,
  input  logic              status_s,
  input  logic              done_s,
  input  logic              init_s,
  input  logic              take_last,
  input  logic              byte_done,
  input  logic              rise,
  output logic              tgt_rst_n,
  output logic              shift_en,
  output logic              toggle_en,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int CW1 = (HOLD_W > TO_W) ? HOLD_W : TO_W;
  localparam int CW  = (CW1 > EXT_W) ? CW1 : EXT_W;

  cfg_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] hold_x;
  logic [CW-1:0] hold_end;
  logic [CW-1:0] to_x;
  logic [CW-1:0] ext_x;
  logic          seen_low;
  logic          last_seen;

  assign hold_x   = CW'(hold_cycles);
  assign hold_end = (hold_x == '0) ? '0 : hold_x - 1'b1;
  assign to_x     = CW'(timeout);
  assign ext_x    = CW'(extra);

  assign busy      = (state != ST_IDLE);
  assign shift_en  = (state == ST_SHIFT);
  assign toggle_en = (state == ST_WAITDN) || ((state == ST_FLUSH) && (cnt != ext_x));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      tgt_rst_n <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      seen_low  <= 1'b0;
      last_seen <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_HOLD;
          cnt       <= '0;
          tgt_rst_n <= 1'b0;
          done      <= 1'b0;
          error     <= 1'b0;
        end
        ST_HOLD: if (cnt == hold_end) begin
          tgt_rst_n <= 1'b1;
          state     <= ST_WAITST;
          cnt       <= '0;
          seen_low  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_WAITST: begin
          if (!status_s) seen_low <= 1'b1;
          if (status_s && seen_low) begin
            state     <= ST_SHIFT;
            last_seen <= 1'b0;
          end else if (cnt == to_x) begin
            state     <= ST_IDLE;
            error     <= 1'b1;
            tgt_rst_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (take_last) last_seen <= 1'b1;
          if (!status_s) begin
            state     <= ST_IDLE;
            error     <= 1'b1;
            tgt_rst_n <= 1'b0;
          end else if (byte_done && last_seen) begin
            state <= ST_WAITDN;
            cnt   <= '0;
          end
        end
        ST_WAITDN: if (done_s) begin
          state <= ST_FLUSH;
          cnt   <= '0;
        end else if (cnt == to_x) begin
          state     <= ST_IDLE;
          error     <= 1'b1;
          tgt_rst_n <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        ST_FLUSH: if (cnt == ext_x) begin
          cnt <= '0;
          if (WAIT_INIT) begin
            state <= ST_WAITIN;
          end else begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end else if (rise) begin
          cnt <= cnt + 1'b1;
        end
        ST_WAITIN: if (init_s) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else if (cnt == to_x) begin
          state     <= ST_IDLE;
          error     <= 1'b1;
          tgt_rst_n <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r3_clock_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (state inside {ST_SHIFT, ST_WAITDN, ST_FLUSH}));

  a_r8_error_pulls_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> !tgt_rst_n);

  a_r7_done_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (tgt_rst_n && ($past(init_s) || !WAIT_INIT)));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

  a_r11_flags_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy);

endmodule

// File: rtl/ps_cfg_host.sv
module ps_cfg_host #(
  parameter int BYTE_W      = 8,
  parameter int DIV_W       = 8,
  parameter int HOLD_W      = 8,
  parameter int TO_W        = 16,
  parameter int EXT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit WAIT_INIT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic [HOLD_W-1:0] hold_cycles,
  input  logic [TO_W-1:0]   timeout,
  input  logic [EXT_W-1:0]  extra_clks,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tgt_rst_n,
  input  logic              tgt_status,
  input  logic              tgt_done,
  input  logic              tgt_init,
  output logic              cfg_clk,
  output logic              cfg_data,
  output logic              busy,
  output logic              done,
  output logic              error
);

  logic [2:0] sync_q;
  logic       status_s;
  logic       done_s;
  logic       init_s;
  logic       shift_en;
  logic       toggle_en;
  logic       tick;
  logic       rise;
  logic       byte_done;
  logic       take_last;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({tgt_init, tgt_done, tgt_status}),
    .q     (sync_q)
  );

  assign status_s  = sync_q[0];
  assign done_s    = sync_q[1];
  assign init_s    = sync_q[2];
  assign take_last = s_valid && s_ready && s_last;

  cfg_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shift_en || toggle_en || cfg_clk),
    .half  (clk_div),
    .tick  (tick)
  );

  cfg_serializer #(.BYTE_W(BYTE_W)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .shift_en  (shift_en),
    .toggle_en (toggle_en),
    .s_data    (s_data),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .dclk      (cfg_clk),
    .dout      (cfg_data),
    .rise      (rise),
    .byte_done (byte_done)
  );

  cfg_seq #(
    .HOLD_W    (HOLD_W),
    .TO_W      (TO_W),
    .EXT_W     (EXT_W),
    .WAIT_INIT (WAIT_INIT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .hold_cycles (hold_cycles),
    .timeout     (timeout),
    .extra       (extra_clks),
    .status_s    (status_s),
    .done_s      (done_s),
    .init_s      (init_s),
    .take_last   (take_last),
    .byte_done   (byte_done),
    .rise        (rise),
    .tgt_rst_n   (tgt_rst_n),
    .shift_en    (shift_en),
    .toggle_en   (toggle_en),
    .busy        (busy),
    .done        (done),
    .error       (error)
  );

  a_r6_take_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (tgt_rst_n && status_s));

endmodule

// File: tb/test_ps_cfg_host.sv
module test_ps_cfg_host;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] clk_div = 8'd3;
  logic [7:0] hold_cycles = 8'd1;
  logic [15:0] timeout = 16'd300;
  logic [3:0] extra_clks = 4'd0;
  logic [7:0] s_data = 8'd0;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic       tgt_rst_n;
  logic       tgt_status = 1'b0;
  logic       tgt_done = 1'b0;
  logic       tgt_init = 1'b0;
  logic       cfg_clk;
  logic       cfg_data;
  logic       busy;
  logic       done;
  logic       error;

  always #2 clk = ~clk;

  ps_cfg_host i_ps_cfg_host (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
    .hold_cycles(hold_cycles), .timeout(timeout), .extra_clks(extra_clks),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .tgt_rst_n(tgt_rst_n), .tgt_status(tgt_status), .tgt_done(tgt_done),
    .tgt_init(tgt_init), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .busy(busy), .done(done), .error(error)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] txb [16];
  logic [7:0] rx [16];
  int  rx_bits, exp_n, ext_rises, exp_half;
  bit  done_req, dropped;
  bit  mdl_status_ok, mdl_drop, mdl_done_ok, mdl_init_ok;
  int  st_cnt, in_cnt, low_cnt, hi_cnt;
  int  v_hi, v_chg, v_rdy, v_pre;
  logic prev_clk, prev_data;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Target model: capture on rising configuration clock
  always @(posedge cfg_clk) begin
    if (!tgt_status) v_pre++;
    if (tgt_rst_n && tgt_status) begin
      if (done_req) ext_rises++;
      else begin
        if (rx_bits < 128) rx[rx_bits/8][rx_bits%8] = cfg_data;
        rx_bits++;
        if (rx_bits == 8*exp_n && mdl_done_ok) done_req = 1'b1;
      end
    end
  end

  // Target model handshakes and bench monitors
  always @(negedge clk) begin
    if (!tgt_rst_n) begin
      tgt_status <= 1'b0; tgt_done <= 1'b0; tgt_init <= 1'b0;
      st_cnt = 0; in_cnt = 0;
    end else begin
      if (!tgt_status && mdl_status_ok && !dropped) begin
        st_cnt++;
        if (st_cnt == 5) tgt_status <= 1'b1;
      end
      if (mdl_drop && rx_bits >= 12) begin tgt_status <= 1'b0; dropped = 1'b1; end
      if (done_req) tgt_done <= 1'b1;
      if (tgt_done && mdl_init_ok) begin
        in_cnt++;
        if (in_cnt == 25) tgt_init <= 1'b1;
      end
    end
    if (cfg_clk) hi_cnt++;
    else begin
      if (hi_cnt != 0 && hi_cnt != exp_half) v_hi++;
      hi_cnt = 0;
    end
    if (prev_clk === 1'b1 && cfg_data !== prev_data) v_chg++;
    prev_clk = cfg_clk; prev_data = cfg_data;
    if (s_ready && (cfg_clk || !busy || !tgt_rst_n)) v_rdy++;
    if (busy && !tgt_rst_n) low_cnt++;
  end

  task automatic send(int n, bit poke);
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1; s_data = txb[i]; s_last = (i == n-1);
      while (!s_ready && busy) @(negedge clk);
      if (!busy) break;
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0; s_data = ~s_data;
      if (poke && i == 0) begin start = 1'b1; @(negedge clk); start = 1'b0; end
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  // mode: 0 normal, 1 status never high, 2 status drops, 3 no done, 4 no init
  task automatic run(int div, int hold, int extra, int n, int mode, bit poke);
    int k;
    int mism;
    @(negedge clk);
    clk_div = 8'(div); hold_cycles = 8'(hold); extra_clks = 4'(extra);
    exp_half = eff(div); exp_n = n;
    mdl_status_ok = (mode != 1); mdl_drop = (mode == 2);
    mdl_done_ok = (mode != 3);   mdl_init_ok = (mode != 4);
    rx_bits = 0; done_req = 1'b0; dropped = 1'b0; ext_rises = 0; low_cnt = 0;
    v_hi = 0; v_chg = 0; v_rdy = 0; v_pre = 0;
    for (int i = 0; i < 16; i++) rx[i] = 8'h00;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    send(n, poke);
    k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    repeat (12) @(negedge clk);
    chk(v_chg == 0, "R4 data changed while clock high", v_chg, 0);
    chk(cfg_clk == 1'b0 && cfg_data == 1'b0, "R10 lines parked low",
        int'({cfg_clk, cfg_data}), 0);
    chk(v_rdy == 0, "R6 ready outside allowed window", v_rdy, 0);
    if (mode == 0) begin
      mism = 0;
      for (int i = 0; i < n; i++) if (rx[i] !== txb[i]) mism++;
      chk(done && !error, "R7 load completes", int'({done, error}), 2);
      chk(low_cnt == eff(hold), "R2 reset low length", low_cnt, eff(hold));
      chk(mism == 0 && rx_bits == 8*n, "R4 bytes LSB first", rx_bits, 8*n);
      chk(v_hi == 0, "R5 high phase length", v_hi, 0);
      chk(v_pre == 0, "R3 clock before status", v_pre, 0);
      if (div >= 3) chk(ext_rises == extra, "R7 extra clocks", ext_rises, extra);
      chk(tgt_rst_n == 1'b1, "R10 reset stays released", int'(tgt_rst_n), 1);
      chk(done == 1'b1 && !busy, "R11 done holds", int'(done), 1);
    end else if (mode == 1) begin
      chk(error && !done, "R9 status timeout", int'({done, error}), 1);
      chk(rx_bits == 0, "R3 no clock without status", rx_bits, 0);
    end else if (mode == 2) begin
      chk(error && !done, "R8 status drop aborts", int'({done, error}), 1);
      chk(tgt_rst_n == 1'b0, "R8 target reset reasserted", int'(tgt_rst_n), 0);
    end else if (mode == 3) begin
      chk(error && !done, "R9 done timeout", int'({done, error}), 1);
      chk(tgt_rst_n == 1'b0, "R9 target reset reasserted", int'(tgt_rst_n), 0);
    end else begin
      chk(error && !done, "R9 init timeout", int'({done, error}), 1);
      if (div >= 3) chk(ext_rises == extra, "R7 extra clocks before init", ext_rises, extra);
    end
  endtask

  initial begin
    repeat (20000 * 5) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    prev_clk = 1'b0; prev_data = 1'b0; exp_half = 3;
    repeat (4) @(negedge clk);
    chk(!tgt_rst_n && !cfg_clk && !cfg_data && !busy && !done && !error && !s_ready,
        "R1 reset state",
        int'({tgt_rst_n, cfg_clk, cfg_data, busy, done, error, s_ready}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tgt_rst_n && !busy && !s_ready, "R1 idle after reset",
        int'({tgt_rst_n, busy, s_ready}), 0);

    txb[0] = 8'h01; txb[1] = 8'h80; txb[2] = 8'hA5;
    run(3, 0, 0, 1, 0, 1'b0);
    run(4, 5, 2, 3, 0, 1'b0);
    run(0, 2, 1, 2, 0, 1'b0);
    run(1, 1, 3, 3, 0, 1'b0);
    for (int i = 0; i < 16; i++) txb[i] = 8'($urandom_range(0, 255));
    run(3, 3, 4, 4, 0, 1'b1);
    chk(done && !error, "R11 start while busy ignored", int'({done, error}), 2);
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < 16; i++) txb[i] = 8'($urandom_range(0, 255));
      run($urandom_range(3, 5), $urandom_range(0, 6), $urandom_range(0, 5),
          $urandom_range(1, 6), 0, 1'b0);
    end
    run(3, 2, 1, 3, 1, 1'b0);
    run(3, 2, 1, 4, 2, 1'b0);
    run(4, 1, 2, 2, 3, 1'b0);
    run(3, 1, 3, 2, 4, 1'b0);
    chk(error && !done, "R11 error holds while idle", int'({done, error}), 1);
    run(5, 4, 5, 5, 0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule